// File: doc/BRIEF.md
# Per-Core Activity Monitor Counter Bank

This block keeps a set of 64-bit event counters beside a processor core for power and performance management. A fixed group of four counters tracks core clock cycles, ticks of a constant-rate system timebase, retired instructions and dispatch stall cycles caused by last-level-cache misses. A second group holds a parameterised number (up to sixteen) of auxiliary counters, each driven by its own event strobe. Every counter has its own enable. While the core sits in a low-power wait, nothing advances.

Software reaches the counters through a one-request-per-cycle register port. A request carries a group select, a 4-bit index, a read or write flag, write data, the requester's privilege level, a guest flag and a user-access enable. One cycle after each request, a single-cycle response reports one of five outcomes: read data, write acknowledge, reserved-index error, privilege trap or undefined-instruction.

The access sequencer is a small state machine whose state names the response being presented. The states are ST_IDLE (no response), ST_DATA (read data), ST_WACK (write acknowledged), ST_RSVD (reserved index), ST_TRAP (user access without permission) and ST_UNDEF (guest access). Transitions are taken on every clock edge from any state:
- no request goes to ST_IDLE;
- a guest request goes to ST_UNDEF;
- a user request without the enable goes to ST_TRAP;
- an illegal index goes to ST_RSVD;
- a legal write goes to ST_WACK;
- a legal read goes to ST_DATA.

These rules are tested top-down in the order listed. There is no handshake, so back-to-back requests produce back-to-back responses.

Top module: `act_mon_bank`

## Requirements
- R1: While reset is low, and afterwards until an event or write occurs, every counter holds zero.
- R2: Group 0 (grp=0) index 0 counts `ev_core`, index 1 counts `ev_tick`, index 2 counts `ev_retire` and index 3 counts `ev_stall`, each by one per cycle its strobe is high, and no other strobe affects it.
- R3: Group 1 (grp=1) index n, for n below AUX_N, counts `ev_aux[n]` by one per cycle its strobe is high.
- R4: While `in_wait` is high, no counter changes on events.
- R5: A counter whose enable is low does not count and reads as zero. It keeps its value, which reads back once the counter is re-enabled.
- R6: A counter at all-ones wraps to zero on its next event.
- R7: A legal write loads the written value at the request edge, so a read in the next cycle returns it. A write takes priority over an event for the same counter in that cycle.
- R8: Group 0 indices 4..15 and group 1 indices AUX_N..15 are reserved. An access to one gives `rsp_err`=1 with data zero, and a write to one changes no counter.
- R9: When `priv` is 0 (user) and `user_ok` is 0, an access gives `rsp_trap`=1 with data zero, and a write changes nothing. Privilege values 1..3, or user with `user_ok`=1, are served normally.
- R10: A request with `guest`=1 gives `rsp_undef`=1 with `rsp_trap`=0 and data zero, whatever the privilege, and a write changes nothing.
- R11: `rsp_valid` is high for exactly the cycle after each request cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| ev_core | input | 1 | Core cycle event strobe |
| ev_tick | input | 1 | Constant-rate timebase tick strobe |
| ev_retire | input | 1 | Instruction retired strobe |
| ev_stall | input | 1 | Last-level-cache stall cycle strobe |
| ev_aux | input | AUX_N | Auxiliary event strobes |
| in_wait | input | 1 | Core in low-power wait state |
| en_fix | input | 4 | Enables of the group 0 counters |
| en_aux | input | AUX_N | Enables of the group 1 counters |
| priv | input | 2 | Requester privilege, 0 = user |
| user_ok | input | 1 | User-level access permitted |
| guest | input | 1 | Request comes from a virtualised guest |
| acc_req | input | 1 | Access request valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_grp | input | 1 | Group select |
| acc_idx | input | 4 | Counter index within the group |
| acc_wdata | input | CNT_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | CNT_W | Read data |
| rsp_err | output | 1 | Reserved index response |
| rsp_trap | output | 1 | Privilege trap response |
| rsp_undef | output | 1 | Undefined-instruction response |

## Verification
The bench uses 12 auxiliary counters, so that both groups have reserved indices. It pulses each of the sixteen event strobes on its own for a distinct number of cycles and reads every counter after each burst. This tells a swapped or cross-wired strobe from a correct one, because each counter ends with a unique count. A burst on all strobes at once, a burst under wait, and a burst with alternate enables low then separate counting from freezing and masking. Directed writes of all-ones, and a write that collides with an event, cover wrap and priority. Sweeps over every reserved index, and over the privilege and guest combinations, check that each fault kind is reported distinctly and leaves the counters untouched.

// File: rtl/act_mon_pkg.sv
`timescale 1ns/1ps
package act_mon_pkg;

    localparam int NFIX    = 4;
    localparam int SLOT_N  = 16;
    localparam int IDX_W   = $clog2(SLOT_N);

    localparam logic [1:0] PRIV_USER = 2'd0;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DATA  = 3'd1,
        ST_WACK  = 3'd2,
        ST_RSVD  = 3'd3,
        ST_TRAP  = 3'd4,
        ST_UNDEF = 3'd5
    } acc_state_e;

endpackage

// File: rtl/act_mon_counter.sv
`timescale 1ns/1ps
module act_mon_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Write beats an event in the same cycle; all-ones wraps to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/act_mon_readmux.sv
`timescale 1ns/1ps
module act_mon_readmux #(
    parameter int W    = 64,
    parameter int NCNT = 20
) (
    input  logic [NCNT-1:0][W-1:0] cnt,
    input  logic [NCNT-1:0]        en,
    input  logic [NCNT-1:0]        sel_oh,
    output logic [W-1:0]           word
);

    // Disabled or unselected counters contribute zero.
    always_comb begin
        word = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (sel_oh[i] && en[i]) begin
                word = word | cnt[i];
            end
        end
    end

endmodule

// File: rtl/act_mon_access.sv
`timescale 1ns/1ps
module act_mon_access
    import act_mon_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_req,
    input  logic         acc_wr,
    input  logic         legal,
    input  logic [1:0]   priv,
    input  logic         user_ok,
    input  logic         guest,
    input  logic [W-1:0] rd_word,
    output logic         wr_go,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_rdata,
    output logic         rsp_err,
    output logic         rsp_trap,
    output logic         rsp_undef
);

    acc_state_e   state_q;
    acc_state_e   state_d;
    logic [W-1:0] data_q;

    // Next response, decided from the request in priority order.
    always_comb begin
        if (!acc_req) begin
            state_d = ST_IDLE;
        end else if (guest) begin
            state_d = ST_UNDEF;
        end else if (priv == PRIV_USER && !user_ok) begin
            state_d = ST_TRAP;
        end else if (!legal) begin
            state_d = ST_RSVD;
        end else if (acc_wr) begin
            state_d = ST_WACK;
        end else begin
            state_d = ST_DATA;
        end
    end

    assign wr_go = (state_d == ST_WACK);

    // State register and captured read word.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= (state_d == ST_DATA) ? rd_word : '0;
        end
    end

    // Response outputs decoded from the state.
    always_comb begin
        rsp_valid = 1'b1;
        rsp_rdata = '0;
        rsp_err   = 1'b0;
        rsp_trap  = 1'b0;
        rsp_undef = 1'b0;
        unique case (state_q)
            ST_IDLE:  rsp_valid = 1'b0;
            ST_DATA:  rsp_rdata = data_q;
            ST_WACK:  rsp_rdata = '0;
            ST_RSVD:  rsp_err   = 1'b1;
            ST_TRAP:  rsp_trap  = 1'b1;
            ST_UNDEF: rsp_undef = 1'b1;
            default:  rsp_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/act_mon_bank.sv
`timescale 1ns/1ps
module act_mon_bank
    import act_mon_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int AUX_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_core,
    input  logic             ev_tick,
    input  logic             ev_retire,
    input  logic             ev_stall,
    input  logic [AUX_N-1:0] ev_aux,
    input  logic             in_wait,
    input  logic [3:0]       en_fix,
    input  logic [AUX_N-1:0] en_aux,
    input  logic [1:0]       priv,
    input  logic             user_ok,
    input  logic             guest,
    input  logic             acc_req,
    input  logic             acc_wr,
    input  logic             acc_grp,
    input  logic [3:0]       acc_idx,
    input  logic [CNT_W-1:0] acc_wdata,
    output logic             rsp_valid,
    output logic [CNT_W-1:0] rsp_rdata,
    output logic             rsp_err,
    output logic             rsp_trap,
    output logic             rsp_undef
);

    localparam int NCNT = NFIX + AUX_N;

    logic [NCNT-1:0]            ev_vec;
    logic [NCNT-1:0]            en_vec;
    logic [NCNT-1:0]            sel_oh;
    logic [NCNT-1:0]            wr_vec;
    logic [NCNT-1:0][CNT_W-1:0] cnt_all;
    logic [CNT_W-1:0]           rd_word;
    logic                       legal;
    logic                       wr_go;

    // Flat order: fixed group first (fixed order matters), then auxiliaries.
    assign ev_vec = {ev_aux, ev_stall, ev_retire, ev_tick, ev_core};
    assign en_vec = {en_aux, en_fix};

    generate
        for (genvar i = 0; i < NCNT; i++) begin : g_cnt
            if (i < NFIX) begin : g_fix
                assign sel_oh[i] = !acc_grp && (acc_idx == IDX_W'(i));
            end else begin : g_aux
                assign sel_oh[i] = acc_grp && (acc_idx == IDX_W'(i - NFIX));
            end

            assign wr_vec[i] = wr_go && sel_oh[i];

            act_mon_counter #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (ev_vec[i] && en_vec[i] && !in_wait),
                .wr    (wr_vec[i]),
                .wdata (acc_wdata),
                .q     (cnt_all[i])
            );
        end
    endgenerate

    assign legal = |sel_oh;

    act_mon_readmux #(.W(CNT_W), .NCNT(NCNT)) u_rmux (
        .cnt    (cnt_all),
        .en     (en_vec),
        .sel_oh (sel_oh),
        .word   (rd_word)
    );

    act_mon_access #(.W(CNT_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .acc_wr    (acc_wr),
        .legal     (legal),
        .priv      (priv),
        .user_ok   (user_ok),
        .guest     (guest),
        .rd_word   (rd_word),
        .wr_go     (wr_go),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .rsp_trap  (rsp_trap),
        .rsp_undef (rsp_undef)
    );

endmodule

// File: rtl/act_mon_bank_chk.sv
`timescale 1ns/1ps
module act_mon_bank_chk #(
    parameter int W    = 64,
    parameter int NCNT = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_wait,
    input logic [1:0]             priv,
    input logic                   user_ok,
    input logic                   guest,
    input logic                   acc_req,
    input logic                   acc_wr,
    input logic                   acc_grp,
    input logic [3:0]             acc_idx,
    input logic [W-1:0]           acc_wdata,
    input logic                   rsp_valid,
    input logic [W-1:0]           rsp_rdata,
    input logic                   rsp_err,
    input logic                   rsp_trap,
    input logic                   rsp_undef,
    input logic [NCNT-1:0][W-1:0] cnt_all
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (cnt_all == '0));

    a_r11_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> rsp_valid);

    a_r11_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |=> !rsp_valid);

    a_r10_guest_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && guest) |=> (rsp_undef && !rsp_trap && rsp_rdata == '0));

    a_r9_user_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !guest && priv == 2'd0 && !user_ok)
            |=> (rsp_trap && !rsp_undef && rsp_rdata == '0));

    a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0 && !rsp_trap && !rsp_undef));

    a_r4_wait_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !(acc_req && acc_wr)) |=> $stable(cnt_all));

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_wr && !guest && priv != 2'd0 && !acc_grp && acc_idx == 4'd0)
            |=> (cnt_all[0] == $past(acc_wdata)));

endmodule

bind act_mon_bank act_mon_bank_chk #(.W(CNT_W), .NCNT(NCNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_wait   (in_wait),
    .priv      (priv),
    .user_ok   (user_ok),
    .guest     (guest),
    .acc_req   (acc_req),
    .acc_wr    (acc_wr),
    .acc_grp   (acc_grp),
    .acc_idx   (acc_idx),
    .acc_wdata (acc_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .rsp_trap  (rsp_trap),
    .rsp_undef (rsp_undef),
    .cnt_all   (cnt_all)
);

// File: tb/act_mon_bank_bench.sv
`timescale 1ns/1ps
module act_mon_bank_bench;

    localparam int AUXN = 12;
    localparam int NC   = 4 + AUXN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ev_core = 0, ev_tick = 0, ev_retire = 0, ev_stall = 0;
    logic [AUXN-1:0] ev_aux = '0;
    logic            in_wait = 0;
    logic [NC-1:0]   en_bits = '1;
    logic [1:0]      priv = 2'd1;
    logic            user_ok = 0, guest = 0;
    logic            acc_req = 0, acc_wr = 0, acc_grp = 0;
    logic [3:0]      acc_idx = '0;
    logic [63:0]     acc_wdata = '0;
    logic            rsp_valid, rsp_err, rsp_trap, rsp_undef;
    logic [63:0]     rsp_rdata;

    logic [63:0]     expv [NC];
    logic            r_valid, r_err, r_trap, r_undef;
    logic [63:0]     r_data;
    int              tests = 0;
    int              fails = 0;
    bit              done = 0;

    always #2.5 clk = ~clk;

    act_mon_bank #(.CNT_W(64), .AUX_N(AUXN)) u_act_mon_bank (
        .clk(clk), .rst_n(rst_n),
        .ev_core(ev_core), .ev_tick(ev_tick), .ev_retire(ev_retire), .ev_stall(ev_stall),
        .ev_aux(ev_aux), .in_wait(in_wait),
        .en_fix(en_bits[3:0]), .en_aux(en_bits[NC-1:4]),
        .priv(priv), .user_ok(user_ok), .guest(guest),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_grp(acc_grp), .acc_idx(acc_idx),
        .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .rsp_trap(rsp_trap), .rsp_undef(rsp_undef)
    );

    task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_ev(input logic [NC-1:0] m);
        ev_core   = m[0];
        ev_tick   = m[1];
        ev_retire = m[2];
        ev_stall  = m[3];
        ev_aux    = m[NC-1:4];
    endtask

    task automatic pulse(input logic [NC-1:0] m, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            set_ev(m);
        end
        @(negedge clk);
        set_ev('0);
        for (int i = 0; i < NC; i++)
            if (m[i] && en_bits[i] && !in_wait) expv[i] = expv[i] + 64'(n);
    endtask

    task automatic access(input logic wr, input logic grp, input logic [3:0] idx,
                          input logic [63:0] wd, input logic [NC-1:0] evm);
        @(negedge clk);
        acc_req = 1; acc_wr = wr; acc_grp = grp; acc_idx = idx; acc_wdata = wd;
        set_ev(evm);
        @(negedge clk);
        acc_req = 0; acc_wr = 0;
        set_ev('0);
        r_valid = rsp_valid; r_data = rsp_rdata; r_err = rsp_err;
        r_trap = rsp_trap; r_undef = rsp_undef;
    endtask

    function automatic logic fgrp(input int i); return (i >= 4); endfunction
    function automatic logic [3:0] fidx(input int i); return (i >= 4) ? 4'(i - 4) : 4'(i); endfunction

    task automatic check_all(input string tag);
        for (int i = 0; i < NC; i++) begin
            access(0, fgrp(i), fidx(i), '0, '0);
            check64($sformatf("%s read counter %0d", tag, i), r_data,
                    en_bits[i] ? expv[i] : 64'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < NC; i++) expv[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R11: idle means no response
        @(negedge clk);
        check64("R11 idle valid", {63'd0, rsp_valid}, 64'd0);

        // R1: reset state
        check_all("R1");

        // R2 / R3: each strobe alone, distinct burst lengths
        for (int k = 0; k < NC; k++) begin
            pulse(NC'(1) << k, k + 1);
            check_all(k < 4 ? "R2" : "R3");
        end
        access(0, 0, 4'd0, '0, '0);
        check64("R11 valid after request", {63'd0, r_valid}, 64'd1);

        // R2: all strobes together
        pulse('1, 5);
        check_all("R2 all");

        // R4: wait freezes
        in_wait = 1;
        pulse('1, 7);
        in_wait = 0;
        check_all("R4");

        // R5: alternate enables low
        en_bits = {(NC/2){2'b10}};
        pulse('1, 3);
        check_all("R5 masked");
        en_bits = '1;
        check_all("R5 reenabled");

        // R6: wrap
        access(1, 0, 4'd1, '1, '0); expv[1] = '1;
        access(1, 1, 4'd2, '1, '0); expv[6] = '1;
        access(0, 0, 4'd1, '0, '0);
        check64("R6 all-ones loaded", r_data, '1);
        pulse(NC'(16'h0042), 1);
        access(0, 0, 4'd1, '0, '0);
        check64("R6 fixed wrap", r_data, 64'd0);
        access(0, 1, 4'd2, '0, '0);
        check64("R6 aux wrap", r_data, 64'd0);
        expv[1] = 64'd0; expv[6] = 64'd0;

        // R7: write beats simultaneous event, visible next cycle
        access(1, 0, 4'd0, 64'h1234_5678_9abc_def0, NC'(1));
        check64("R7 write ack valid", {63'd0, r_valid}, 64'd1);
        access(0, 0, 4'd0, '0, '0);
        check64("R7 write wins", r_data, 64'h1234_5678_9abc_def0);
        expv[0] = 64'h1234_5678_9abc_def0;
        access(1, 1, 4'd11, 64'd777, NC'(1) << 15);
        access(0, 1, 4'd11, '0, '0);
        check64("R7 aux write wins", r_data, 64'd777);
        expv[15] = 64'd777;

        // R8: reserved indices
        for (int j = 4; j < 16; j++) begin
            access(0, 0, 4'(j), '0, '0);
            check64($sformatf("R8 grp0 idx %0d err", j), {63'd0, r_err}, 64'd1);
            check64($sformatf("R8 grp0 idx %0d data", j), r_data, 64'd0);
        end
        for (int j = AUXN; j < 16; j++) begin
            access(0, 1, 4'(j), '0, '0);
            check64($sformatf("R8 grp1 idx %0d err", j), {63'd0, r_err}, 64'd1);
            access(1, 1, 4'(j), 64'hdead, '0);
            check64($sformatf("R8 grp1 wr idx %0d err", j), {63'd0, r_err}, 64'd1);
        end
        access(1, 0, 4'd5, 64'hbeef, '0);
        check_all("R8 reserved write ignored");

        // R9: user trap
        priv = 2'd0; user_ok = 0;
        access(0, 0, 4'd2, '0, '0);
        check64("R9 trap flag", {63'd0, r_trap}, 64'd1);
        check64("R9 trap data", r_data, 64'd0);
        access(1, 0, 4'd2, 64'd99, '0);
        check64("R9 trap on write", {63'd0, r_trap}, 64'd1);
        user_ok = 1;
        access(0, 0, 4'd2, '0, '0);
        check64("R9 user allowed trap", {63'd0, r_trap}, 64'd0);
        check64("R9 user allowed data", r_data, expv[2]);
        for (int p = 1; p < 4; p++) begin
            priv = 2'(p); user_ok = 0;
            access(0, 0, 4'd2, '0, '0);
            check64($sformatf("R9 priv %0d data", p), r_data, expv[2]);
        end

        // R10: guest undefined
        guest = 1; priv = 2'd0; user_ok = 0;
        access(0, 1, 4'd0, '0, '0);
        check64("R10 undef flag", {63'd0, r_undef}, 64'd1);
        check64("R10 no trap", {63'd0, r_trap}, 64'd0);
        check64("R10 data", r_data, 64'd0);
        priv = 2'd3;
        access(1, 1, 4'd0, 64'd5, '0);
        check64("R10 undef on write", {63'd0, r_undef}, 64'd1);
        guest = 0;
        check_all("R10 R9 writes ignored");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule